// File: doc/BRIEF.md
# Pin Bank Controller with Per-Pin Interrupt Detection

This block is a bank of general-purpose pins attached to a simple 32-bit register bus with APB-style access. Software owns an output data word and a per-pin direction word. Two dedicated write ports change output bits without a read-modify-write: one drives the selected bits high and the other drives them low. The pin inputs pass through a two-flop synchronizer, and software can read the synchronized value.

Each pin has its own interrupt detector. Three configuration words together choose its trigger: a select word (edge or level), a polarity word, and an any-edge override. A detected event latches a pending bit, but only while that pin is enabled. Software clears pending bits by writing ones. One combined interrupt request is raised when any pending bit is both enabled and not masked. The pull-enable and pull-type words are plain storage and affect nothing else.

Top module: `pio_bank`

## Requirements
- R1: After reset, every register reads zero, `pin_out` and `pin_oe` are zero, and `irq` is low.
- R2: The output word (byte offset 0x00) and the direction word (0x08) read back what was written. `pin_out` follows the output word. `pin_oe` follows the direction word, where bit value 1 makes a pin an output.
- R3: A write to offset 0x10 sets every output bit whose written bit is 1 and leaves the other bits unchanged.
- R4: A write to offset 0x14 clears every output bit whose written bit is 1 and leaves the other bits unchanged.
- R5: Offset 0x04 reads the pin inputs after a two-stage synchronizer.
- R6: Edge detection applies when the select word (0x34) bit is 0. With any-edge (0x38) bit 0 and polarity (0x3C) bit 0, only a 0-to-1 transition sets the pending bit.
- R7: With the select bit 0, the any-edge bit 0 and the polarity bit 1, only a 1-to-0 transition sets the pending bit.
- R8: With the select bit 0 and the any-edge bit 1, either transition sets the pending bit, whatever the polarity bit holds.
- R9: Level detection applies when the select bit is 1. The pending bit is set while the pin is high when polarity is 0, and while the pin is low when polarity is 1.
- R10: Writing 1 to a bit at offset 0x30 clears that pending bit (read at 0x24), and bits written as 0 change nothing. The clear takes priority in the write cycle, so a level-mode pin whose level is still active sets its bit again on the next cycle.
- R11: A pending bit can be set only while its enable bit (0x20) is 1. Events that occur while the pin is disabled are not remembered.
- R12: `irq` is high exactly when some pending bit has its enable bit at 1 and its mask bit (0x2C) at 0.
- R13: The pull-enable (0x18) and pull-type (0x1C) words read back what was written and affect no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 for a write, 0 for a read |
| paddr | input | 8 | Byte address, word aligned |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| pin_in | input | 32 | Asynchronous pin inputs |
| pin_out | output | 32 | Output data to the pins |
| pin_oe | output | 32 | Per-pin output enable |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume that each bus access is a two-phase transfer: select alone for one cycle, then select with enable, with the address and data held steady throughout. They also assume that the address is word aligned, so each register is decoded from one exact byte address. The bench drives every transfer through a single task that keeps to this shape and uses only the listed offsets. It changes `pin_in` only on falling clock edges and waits for the synchronizer and the pending register to settle before it reads.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;

  typedef logic [DATA_W-1:0] word_t;
  typedef logic [ADDR_W-1:0] addr_t;

  // register byte offsets
  localparam addr_t OFS_OUT   = 8'h00;
  localparam addr_t OFS_IN    = 8'h04;
  localparam addr_t OFS_DIR   = 8'h08;
  localparam addr_t OFS_SET   = 8'h10;
  localparam addr_t OFS_CLR   = 8'h14;
  localparam addr_t OFS_PLEN  = 8'h18;
  localparam addr_t OFS_PLTY  = 8'h1C;
  localparam addr_t OFS_IEN   = 8'h20;
  localparam addr_t OFS_IPEND = 8'h24;
  localparam addr_t OFS_IMSK  = 8'h2C;
  localparam addr_t OFS_IACK  = 8'h30;
  localparam addr_t OFS_ISEL  = 8'h34;
  localparam addr_t OFS_IANY  = 8'h38;
  localparam addr_t OFS_IPOL  = 8'h3C;
endpackage

// File: rtl/pio_rst_sync.sv
module pio_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/pio_sync.sv
module pio_sync #(
  parameter int N      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] sync_out
);
  logic [N-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [N-1:0] stage_d;
      if (s == 0) begin : g_first
        assign stage_d = async_in;
      end else begin : g_next
        assign stage_d = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_d;
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/pio_detect.sv
module pio_detect #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_s,
  input  logic [N-1:0] lvl_sel,
  input  logic [N-1:0] pol,
  input  logic [N-1:0] any_edge,
  output logic [N-1:0] hit
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= pin_s;
  end

  generate
    for (genvar i = 0; i < N; i++) begin : g_pin
      logic rise, fall, edge_hit, level_hit;
      always_comb begin
        rise      = pin_s[i] & ~prev_q[i];
        fall      = ~pin_s[i] & prev_q[i];
        level_hit = pin_s[i] ^ pol[i];
        if (any_edge[i]) edge_hit = rise | fall;
        else if (pol[i]) edge_hit = fall;
        else             edge_hit = rise;
        hit[i] = lvl_sel[i] ? level_hit : edge_hit;
      end
    end
  endgenerate
endmodule

// File: rtl/pio_regs.sv
module pio_regs
  import pio_pkg::*;
#(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         psel,
  input  logic         penable,
  input  logic         pwrite,
  input  addr_t        paddr,
  input  word_t        pwdata,
  output word_t        prdata,
  input  logic [N-1:0] pin_s,
  input  logic [N-1:0] hit,
  output logic [N-1:0] out_q,
  output logic [N-1:0] dir_q,
  output logic [N-1:0] lvl_sel_q,
  output logic [N-1:0] pol_q,
  output logic [N-1:0] any_q,
  output logic         irq
);
  logic [N-1:0] plen_q, plty_q, ien_q, imsk_q, pend_q;
  logic [N-1:0] out_n, pend_n;
  logic [N-1:0] wdata;
  logic         wr;
  logic w_out, w_dir, w_set, w_clr, w_plen, w_plty;
  logic w_ien, w_imsk, w_iack, w_isel, w_iany, w_ipol;

  assign wr    = psel & penable & pwrite;
  assign wdata = pwdata[N-1:0];

  always_comb begin
    w_out  = wr && (paddr == OFS_OUT);
    w_dir  = wr && (paddr == OFS_DIR);
    w_set  = wr && (paddr == OFS_SET);
    w_clr  = wr && (paddr == OFS_CLR);
    w_plen = wr && (paddr == OFS_PLEN);
    w_plty = wr && (paddr == OFS_PLTY);
    w_ien  = wr && (paddr == OFS_IEN);
    w_imsk = wr && (paddr == OFS_IMSK);
    w_iack = wr && (paddr == OFS_IACK);
    w_isel = wr && (paddr == OFS_ISEL);
    w_iany = wr && (paddr == OFS_IANY);
    w_ipol = wr && (paddr == OFS_IPOL);
  end

  // next-state: output word and pending bits
  always_comb begin
    out_n = out_q;
    if (w_out) out_n = wdata;
    if (w_set) out_n = out_q | wdata;
    if (w_clr) out_n = out_q & ~wdata;
    pend_n = (pend_q | (hit & ien_q)) & ~(w_iack ? wdata : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q     <= '0;
      dir_q     <= '0;
      plen_q    <= '0;
      plty_q    <= '0;
      ien_q     <= '0;
      imsk_q    <= '0;
      lvl_sel_q <= '0;
      any_q     <= '0;
      pol_q     <= '0;
      pend_q    <= '0;
    end else begin
      if (w_out | w_set | w_clr) out_q <= out_n;
      if (w_dir)  dir_q     <= wdata;
      if (w_plen) plen_q    <= wdata;
      if (w_plty) plty_q    <= wdata;
      if (w_ien)  ien_q     <= wdata;
      if (w_imsk) imsk_q    <= wdata;
      if (w_isel) lvl_sel_q <= wdata;
      if (w_iany) any_q     <= wdata;
      if (w_ipol) pol_q     <= wdata;
      pend_q <= pend_n;
    end
  end

  always_comb begin
    prdata = '0;
    case (paddr)
      OFS_OUT:   prdata = word_t'(out_q);
      OFS_IN:    prdata = word_t'(pin_s);
      OFS_DIR:   prdata = word_t'(dir_q);
      OFS_PLEN:  prdata = word_t'(plen_q);
      OFS_PLTY:  prdata = word_t'(plty_q);
      OFS_IEN:   prdata = word_t'(ien_q);
      OFS_IPEND: prdata = word_t'(pend_q);
      OFS_IMSK:  prdata = word_t'(imsk_q);
      OFS_ISEL:  prdata = word_t'(lvl_sel_q);
      OFS_IANY:  prdata = word_t'(any_q);
      OFS_IPOL:  prdata = word_t'(pol_q);
      default:   prdata = '0;
    endcase
  end

  always_comb irq = |(pend_q & ien_q & ~imsk_q);

  // R3
  set_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(w_set) |-> ((out_q & $past(wdata)) == $past(wdata)));

  // R4
  clr_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(w_clr) |-> ((out_q & $past(wdata)) == '0));

  // R10
  pend_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(w_iack) |-> ((pend_q & $past(wdata)) == '0));

  // R11
  pend_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~$past(pend_q) & ~$past(ien_q)) == '0));

  // R12
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == '0) |-> !irq);
endmodule

// File: rtl/pio_bank.sv
module pio_bank
  import pio_pkg::*;
#(
  parameter int N           = 32,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  input  logic [N-1:0]      pin_in,
  output logic [N-1:0]      pin_out,
  output logic [N-1:0]      pin_oe,
  output logic              irq
);
  logic         rst_i_n;
  logic [N-1:0] pin_s, hit, lvl_sel, pol, any_edge;

  pio_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  pio_sync #(.N(N), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_i_n), .async_in(pin_in), .sync_out(pin_s)
  );

  pio_detect #(.N(N)) u_det (
    .clk(clk), .rst_n(rst_i_n), .pin_s(pin_s), .lvl_sel(lvl_sel),
    .pol(pol), .any_edge(any_edge), .hit(hit)
  );

  pio_regs #(.N(N)) u_regs (
    .clk(clk), .rst_n(rst_i_n), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pin_s(pin_s), .hit(hit), .out_q(pin_out), .dir_q(pin_oe),
    .lvl_sel_q(lvl_sel), .pol_q(pol), .any_q(any_edge), .irq(irq)
  );
endmodule

// File: tb/tb_pio_bank.sv
module tb_pio_bank;
  import pio_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        psel, penable, pwrite;
  logic [7:0]  paddr;
  logic [31:0] pwdata, prdata;
  logic [31:0] pin_in, pin_out, pin_oe;
  logic        irq;

  int n_chk  = 0;
  int n_fail = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] act_q[$];

  always #5 clk = ~clk;

  pio_bank dut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compares observed reads against queued expectations
  always @(posedge clk) begin
    while (act_q.size() > 0 && exp_q.size() > 0)
      chk(tag_q.pop_front(), act_q.pop_front(), exp_q.pop_front());
  end

  task automatic bus_wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  // driver: queue the expectation, then perform the read
  task automatic expect_rd(logic [7:0] a, logic [31:0] e, string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    #2;
    act_q.push_back(prdata);
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    repeat (3) @(posedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    paddr = '0; pwdata = '0; pin_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 pin_out", pin_out, 32'h0);
    chk("R1 pin_oe", pin_oe, 32'h0);
    expect_rd(OFS_OUT,   32'h0, "R1 out word");
    expect_rd(OFS_IEN,   32'h0, "R1 enable word");
    expect_rd(OFS_IPEND, 32'h0, "R1 pending word");
    expect_rd(OFS_ISEL,  32'h0, "R1 select word");

    // R2 output and direction
    bus_wr(OFS_OUT, 32'hA5A5_0F0F);
    expect_rd(OFS_OUT, 32'hA5A5_0F0F, "R2 out readback");
    chk("R2 pin_out", pin_out, 32'hA5A5_0F0F);
    bus_wr(OFS_DIR, 32'hFFFF_0000);
    expect_rd(OFS_DIR, 32'hFFFF_0000, "R2 dir readback");
    chk("R2 pin_oe", pin_oe, 32'hFFFF_0000);

    // R3 set port
    bus_wr(OFS_SET, 32'h0000_F0F0);
    chk("R3 pin_out after set", pin_out, 32'hA5A5_FFFF);
    // R4 clear port
    bus_wr(OFS_CLR, 32'hA5A0_0000);
    chk("R4 pin_out after clear", pin_out, 32'h0005_FFFF);
    expect_rd(OFS_OUT, 32'h0005_FFFF, "R4 out readback");

    // R5 synchronized input
    pin_in = 32'h1234_5678;
    settle();
    expect_rd(OFS_IN, 32'h1234_5678, "R5 input readback");

    // interrupt setup: pin0 rise, pin1 fall, pin2/3 any edge, pin4 level high, pin5 level low
    pin_in = 32'h0000_0020;
    settle();
    bus_wr(OFS_ISEL, 32'h0000_0030);
    bus_wr(OFS_IPOL, 32'h0000_002A);
    bus_wr(OFS_IANY, 32'h0000_000C);
    bus_wr(OFS_IEN,  32'h0000_003F);
    bus_wr(OFS_IMSK, 32'h0);
    bus_wr(OFS_IACK, 32'hFFFF_FFFF);
    expect_rd(OFS_IPEND, 32'h0, "R11 nothing latched while disabled");

    // R6 and R8 rising transitions
    pin_in = 32'h0000_002F;
    settle();
    expect_rd(OFS_IPEND, 32'h0000_000D, "R6 R8 rising");
    chk("R12 irq raised", {31'b0, irq}, 32'h1);
    bus_wr(OFS_IACK, 32'h0000_000D);
    expect_rd(OFS_IPEND, 32'h0, "R10 clear by ones");

    // R7 and R8 falling transitions
    pin_in = 32'h0000_0020;
    settle();
    expect_rd(OFS_IPEND, 32'h0000_000E, "R7 R8 falling");
    bus_wr(OFS_IACK, 32'h0);
    expect_rd(OFS_IPEND, 32'h0000_000E, "R10 zero write no effect");
    bus_wr(OFS_IACK, 32'hFFFF_FFFF);
    expect_rd(OFS_IPEND, 32'h0, "R10 clear all");

    // R9 levels
    pin_in = 32'h0000_0030;
    settle();
    expect_rd(OFS_IPEND, 32'h0000_0010, "R9 active high");
    pin_in = 32'h0000_0010;
    settle();
    expect_rd(OFS_IPEND, 32'h0000_0030, "R9 active low");

    // R10 level reassert after clear
    bus_wr(OFS_IACK, 32'h0000_0030);
    chk("R10 cleared in write cycle", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R10 level reasserts", {31'b0, irq}, 32'h1);

    pin_in = 32'h0000_0020;
    settle();
    bus_wr(OFS_IACK, 32'hFFFF_FFFF);
    expect_rd(OFS_IPEND, 32'h0, "R10 idle after levels gone");

    // R12 mask and enable gating
    bus_wr(OFS_IMSK, 32'h0000_0001);
    pin_in = 32'h0000_0021;
    settle();
    expect_rd(OFS_IPEND, 32'h0000_0001, "R6 pending while masked");
    chk("R12 masked irq low", {31'b0, irq}, 32'h0);
    bus_wr(OFS_IMSK, 32'h0);
    chk("R12 unmasked irq high", {31'b0, irq}, 32'h1);
    bus_wr(OFS_IEN, 32'h0000_003E);
    chk("R12 disabled irq low", {31'b0, irq}, 32'h0);
    expect_rd(OFS_IPEND, 32'h0000_0001, "R12 pending kept");

    // R11 events while disabled are dropped
    bus_wr(OFS_IACK, 32'hFFFF_FFFF);
    pin_in = 32'h0000_0020;
    settle();
    pin_in = 32'h0000_0021;
    settle();
    bus_wr(OFS_IEN, 32'h0000_003F);
    expect_rd(OFS_IPEND, 32'h0, "R11 disabled edge dropped");
    chk("R11 irq low", {31'b0, irq}, 32'h0);

    // R13 pull storage
    bus_wr(OFS_PLEN, 32'hDEAD_BEEF);
    bus_wr(OFS_PLTY, 32'h0F0F_0F0F);
    expect_rd(OFS_PLEN, 32'hDEAD_BEEF, "R13 pull enable readback");
    expect_rd(OFS_PLTY, 32'h0F0F_0F0F, "R13 pull type readback");
    chk("R13 pin_out untouched", pin_out, 32'h0005_FFFF);
    chk("R13 pin_oe untouched", pin_oe, 32'hFFFF_0000);
    chk("R13 irq untouched", {31'b0, irq}, 32'h0);

    finish_run();
  end
endmodule